// File: doc/BRIEF.md
# Byte FIFO with Programmable Level Flags

This block buffers the bytes of one serial channel, in either direction, in a single clock domain. A producer pulses a write strobe with a byte and a consumer pulses a read strobe. The consumer sees the oldest byte on the read data output in the cycle after its strobe is accepted. Storage depth is a parameter. The shipped default is 4096 entries so that the default build stays small. Channel buffers of 32K bytes are made by overriding the parameter.

Two 16-bit thresholds, loaded together through one 32-bit write port, set where the FIFO starts to report itself as almost empty and almost full. Along with the separate empty, almost-empty, almost-full and full flags, the block packs these four conditions into a 4-bit status code with a fixed value for each occupancy band. Firmware can read the band as one nibble. A write strobe while full and a read strobe while empty are dropped. Each dropped strobe leaves a sticky error bit, which only reset clears. Synchronous reset empties the storage but keeps the programmed thresholds.

Top module: `lvl_fifo`

## Requirements
- R1: Bytes leave in the order they entered. After an accepted read strobe at a clock edge, `rd_data` shows that byte from that edge until the next accepted read or reset.
- R2: A `thr_we` pulse loads `thr_wdata`. Bits 15:0 are the almost-empty level (AE) and bits 31:16 are the almost-full level (AF). The new levels take effect from the following edge.
- R3: `almost_empty` is high exactly when the stored count is less than or equal to AE.
- R4: `almost_full` is high exactly when the free space (depth minus count) is less than or equal to AF.
- R5: `empty` is high exactly when the count is zero. `full` is high exactly when the count equals the depth.
- R6: `status` is {~full, ~almost_full, ~almost_empty, ~empty} in bits 3..0. This gives 0xC for empty, 0xD for almost empty but not empty, 0xF for the middle band, 0xB for almost full but not full, and 0x3 for full.
- R7: A write strobe while full stores nothing, even if a read happens in the same cycle, and sets the sticky `overflow` bit.
- R8: A read strobe while empty changes neither the count nor `rd_data`, even if a write happens in the same cycle, and sets the sticky `underflow` bit.
- R9: When a write and a read are both accepted in one cycle, the count is unchanged and both transfers take place.
- R10: A cycle with `srst` high empties the FIFO and clears `overflow`, `underflow` and `rd_data`. AE and AF keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Last byte read |
| thr_we | input | 1 | Load the threshold register |
| thr_wdata | input | 32 | {AF, AE} threshold value |
| empty | output | 1 | No bytes stored |
| almost_empty | output | 1 | Count at or below AE |
| almost_full | output | 1 | Free space at or below AF |
| full | output | 1 | Every entry in use |
| status | output | 4 | Packed band code |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read was dropped |

## Verification
The bench walks the count from zero to the depth and back one step at a time. This exposes an off-by-one in either threshold compare, which would move a band edge one entry early or late and show as a wrong code such as 0xF where 0xD belongs. It strobes both ports at full and at empty: a design that gates a strobe by the wrong flag would corrupt the count, lose or duplicate a byte, or leave a sticky bit clear. It resets the block and then refills it with a known pattern: a design that also cleared the thresholds would move the almost-empty edge. Random traffic with random thresholds, including levels above the depth, covers bands in which both almost flags are active.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned LVL_W  = 16;

    typedef struct packed {
        logic [LVL_W-1:0] af_lvl;
        logic [LVL_W-1:0] ae_lvl;
    } lvl_thr_t;

    typedef enum logic [3:0] {
        LVL_EMPTY = 4'hC,
        LVL_LOW   = 4'hD,
        LVL_MID   = 4'hF,
        LVL_HIGH  = 4'hB,
        LVL_FULL  = 4'h3
    } lvl_code_e;

    typedef struct packed {
        logic empty;
        logic a_empty;
        logic a_full;
        logic full;
    } lvl_flags_t;

    function automatic logic [3:0] lvl_pack(input lvl_flags_t f);
        return {~f.full, ~f.a_full, ~f.a_empty, ~f.empty};
    endfunction

endpackage

// File: rtl/lvl_fifo_mem.sv
module lvl_fifo_mem #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (srst)    rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/lvl_fifo_ctrl.sv
module lvl_fifo_ctrl #(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          empty,
    input  logic          full,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          overflow,
    output logic          underflow
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign wr_ok = wr_en && !full;
    assign rd_ok = rd_en && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (srst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full)  overflow  <= 1'b1;
            if (rd_en && empty) underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/lvl_fifo_flags.sv
module lvl_fifo_flags
    import lvl_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned XW   = (CW > LVL_W) ? CW : LVL_W
) (
    input  logic [CW-1:0] count,
    input  lvl_thr_t      thr,
    output lvl_flags_t    flags,
    output logic [3:0]    status
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] space;
    assign space = DEPTH_C - count;

    always_comb begin
        flags.empty   = (count == '0);
        flags.full    = (count == DEPTH_C);
        flags.a_empty = (XW'(count) <= XW'(thr.ae_lvl));
        flags.a_full  = (XW'(space) <= XW'(thr.af_lvl));
        status        = lvl_pack(flags);
    end
endmodule

// File: rtl/lvl_fifo.sv
module lvl_fifo
    import lvl_fifo_pkg::*;
#(
    parameter int unsigned DEPTH    = 4096,
    parameter logic [31:0] THR_INIT = 32'h0008_0008,
    localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        srst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic        thr_we,
    input  logic [31:0] thr_wdata,
    output logic        empty,
    output logic        almost_empty,
    output logic        almost_full,
    output logic        full,
    output logic [3:0]  status,
    output logic        overflow,
    output logic        underflow
);
    lvl_thr_t      thr_q = lvl_thr_t'(THR_INIT);
    lvl_flags_t    flags;
    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (thr_we) thr_q <= lvl_thr_t'(thr_wdata);
    end

    lvl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .srst(srst), .wr_en(wr_en), .rd_en(rd_en),
        .empty(flags.empty), .full(flags.full),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .count(count), .overflow(overflow), .underflow(underflow)
    );

    lvl_fifo_mem #(.DW(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .srst(srst), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
        .re(rd_ok), .raddr(rd_ptr), .rdata(rd_data)
    );

    lvl_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .count(count), .thr(thr_q), .flags(flags), .status(status)
    );

    assign empty        = flags.empty;
    assign almost_empty = flags.a_empty;
    assign almost_full  = flags.a_full;
    assign full         = flags.full;
endmodule

// File: rtl/lvl_fifo_chk.sv
module lvl_fifo_chk
    import lvl_fifo_pkg::*;
(
    input logic       clk,
    input logic       srst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       empty,
    input logic       almost_empty,
    input logic       almost_full,
    input logic       full,
    input logic [3:0] status,
    input logic       overflow,
    input logic       underflow
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        srst |=> empty && !overflow && !underflow && rd_data == 8'h00); // R10

    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (srst)
        full && wr_en && !rd_en |=> full && overflow); // R7

    AST_NO_UNDERFLOW_READ: assert property (@(posedge clk) disable iff (srst)
        empty && rd_en && !wr_en |=> empty && underflow && $stable(rd_data)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (srst)
        overflow |=> overflow); // R7

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (srst)
        underflow |=> underflow); // R8

    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (srst)
        empty && !almost_full |-> status == LVL_EMPTY); // R6

    AST_FULL_CODE: assert property (@(posedge clk) disable iff (srst)
        full && !almost_empty |-> status == LVL_FULL); // R6

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (srst)
        wr_en && !rd_en && !full |=> !empty); // R5

    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (srst)
        wr_en && rd_en && !full && !empty |=> !empty && !full); // R9
endmodule

bind lvl_fifo lvl_fifo_chk u_lvl_fifo_chk (
    .clk(clk), .srst(srst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty), .almost_full(almost_full),
    .full(full), .status(status), .overflow(overflow), .underflow(underflow)
);

// File: tb/lvl_fifo_test.sv
`timescale 1ns/1ps
module lvl_fifo_test;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, thr_we = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [31:0] thr_wdata = '0;
    logic [7:0]  rd_data;
    logic        empty, almost_empty, almost_full, full, overflow, underflow;
    logic [3:0]  status;

    int checks = 0;
    int errors = 0;

    logic [7:0] q[$];
    int         m_ae = 8, m_af = 8;
    logic [7:0] m_rd = 8'h00;
    logic       m_ovf = 1'b0, m_udf = 1'b0;

    always #4 clk = ~clk;

    lvl_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .srst(srst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .empty(empty), .almost_empty(almost_empty), .almost_full(almost_full),
        .full(full), .status(status), .overflow(overflow), .underflow(underflow)
    );

    function automatic logic [3:0] exp_code(int n, int ae, int af);
        return {~(n == DEPTH), ~((DEPTH - n) <= af), ~(n <= ae), ~(n == 0)};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        int n = q.size();
        chk("R5", "empty", int'(empty), int'(n == 0));
        chk("R5", "full", int'(full), int'(n == DEPTH));
        chk("R3", "almost_empty", int'(almost_empty), int'(n <= m_ae));
        chk("R4", "almost_full", int'(almost_full), int'((DEPTH - n) <= m_af));
        chk("R6", "status", int'(status), int'(exp_code(n, m_ae, m_af)));
        chk("R7", "overflow", int'(overflow), int'(m_ovf));
        chk("R8", "underflow", int'(underflow), int'(m_udf));
        chk("R1", "rd_data", int'(rd_data), int'(m_rd));
    endtask

    task automatic cycle(input logic w, input logic [7:0] wd, input logic r,
                         input logic tw, input logic [31:0] td, input logic rs = 1'b0);
        bit was_full, was_empty;
        @(negedge clk);
        wr_en = w; wr_data = wd; rd_en = r; thr_we = tw; thr_wdata = td; srst = rs;
        @(posedge clk);
        was_full  = (q.size() == DEPTH);
        was_empty = (q.size() == 0);
        if (rs) begin
            q.delete(); m_rd = 8'h00; m_ovf = 1'b0; m_udf = 1'b0;
        end else begin
            if (r && !was_empty) m_rd = q.pop_front();
            if (w && !was_full)  q.push_back(wd);
            if (w && was_full)   m_ovf = 1'b1;
            if (r && was_empty)  m_udf = 1'b1;
        end
        if (tw) begin m_ae = int'(td[15:0]); m_af = int'(td[31:16]); end
        #2;
        check_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        // R10 reset state
        check_all();
        // R2: AE=3, AF=5
        cycle(0, 0, 0, 1, 32'h0005_0003);
        chk("R2", "status after load", int'(status), 4'hC);
        // fill one by one: bands C, D, F, B, 3
        for (int i = 0; i < DEPTH; i++) cycle(1, 8'(i * 7 + 1), 0, 0, 0);
        chk("R6", "full code", int'(status), 4'h3);
        // R7: write while full, alone and with a read
        cycle(1, 8'hEE, 0, 0, 0);
        chk("R7", "overflow set", int'(overflow), 1);
        cycle(1, 8'hEF, 1, 0, 0);
        chk("R7", "write dropped with read", int'(full), 0);
        // drain with data check (R1)
        while (q.size() > 0) cycle(0, 0, 1, 0, 0);
        // R8: read while empty, alone and with a write
        cycle(0, 0, 1, 0, 0);
        chk("R8", "underflow set", int'(underflow), 1);
        cycle(1, 8'h5A, 1, 0, 0);
        chk("R8", "read dropped with write", int'(empty), 0);
        // R9: simultaneous accepted read and write
        cycle(1, 8'h11, 0, 0, 0);
        cycle(1, 8'h22, 1, 0, 0);
        chk("R9", "rd_data", int'(rd_data), 8'h5A);
        // R10: reset keeps thresholds (AE=3)
        cycle(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) cycle(1, 8'(i), 0, 0, 0);
        chk("R10", "AE kept after reset", int'(status), 4'hF);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic tw = ($urandom_range(0, 99) < 2);
            logic [31:0] td = {16'($urandom_range(0, 70)), 16'($urandom_range(0, 70))};
            int bias = (i / 500) % 2 ? 70 : 35;
            cycle($urandom_range(0, 99) < bias, 8'($urandom), $urandom_range(0, 99) < (105 - bias),
                  tw, td, $urandom_range(0, 999) < 3);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule